// File: doc/BRIEF.md
# Bit interleave, parity and unpack unit

This is one slice of the execution stage of a 32-bit processor. It carries out four data-rearranging operations, chosen by a two-bit opcode. It can weave the low halves of two operands together bit by bit. It can pull one operand apart into its even-indexed and odd-indexed bits. It can reduce each byte to a parity bit. It can break a single-precision float into a signed exponent and an aligned mantissa. Operands come in with a valid strobe. Exactly one clock later, the block presents a low result word, a high result word and an output valid.

Operations that produce a single word drive the high word to zero. Operations that produce a word pair, split and unpack, fill both words. Only the low result word and the high result word are registered, together with the output valid. When no valid operation arrives, the result registers keep their previous contents.

Top module: `bitops_unit`

## Requirements
- R1: With opcode 0 (interleave), bit i of `opa` (i = 0..15) appears at `res_lo` bit 2i+1 and bit i of `opb` appears at `res_lo` bit 2i. The upper halves of both operands have no effect, and `res_hi` is zero.
- R2: With opcode 1 (de-interleave), `opa` bit 2k goes to `res_lo` bit k and `opa` bit 2k+1 goes to `res_hi` bit k, for k = 0..15. Bits 31:16 of both result words are zero, and `opb` has no effect.
- R3: With opcode 2 (parity), `res_lo` bits 0, 8, 16 and 24 each hold the XOR of operand byte 0, 1, 2 and 3 respectively. Every other bit of `res_lo` is zero, and `res_hi` is zero.
- R4: With opcode 3 (unpack), the exponent field is `opa` bits 30:23 and the fraction is bits 22:0. When the exponent field is 255, `res_hi` is 255 and `res_lo` is the fraction shifted left by 7.
- R5: With opcode 3, when both the exponent field and the fraction are zero, `res_hi` is -127 (0xFFFFFF81) and `res_lo` is 0.
- R6: With opcode 3, when the exponent field is zero and the fraction is nonzero, `res_hi` is -126 (0xFFFFFF82) and `res_lo` is the fraction shifted left by 7.
- R7: With opcode 3 and an exponent field from 1 to 254, `res_hi` is the field minus 127 as a 32-bit two's-complement value. `res_lo` is the fraction shifted left by 7 with bit 30 set and bit 31 clear.
- R8: With opcode 3, `opa` bit 31 (the float sign) has no effect on either result word.
- R9: `out_valid` equals `in_valid` delayed by one clock. The results of an operation are visible in the cycle where `out_valid` is high.
- R10: A synchronous active-high `rst` clears `out_valid`, `res_lo` and `res_hi` at the next rising edge.
- R11: In a cycle with `in_valid` low, `res_lo` and `res_hi` keep their values, whatever the opcode and operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 2 | Operation: 0 interleave, 1 de-interleave, 2 parity, 3 unpack |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (used by interleave only) |
| out_valid | output | 1 | Result words are valid |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |

## Verification
The state that can go wrong is the result and valid register stage. A wrong mapping, a missing hidden bit or a bad exponent bias shows up as a wrong bit in `res_lo` or `res_hi` in the single cycle after the operation is issued. There is no later stage in which such an error could be masked or corrected. A hold fault, where the registers load while `in_valid` is low, changes the outputs one edge after the idle cycle. A stuck or delayed valid bit shows up on `out_valid` at that same edge.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    // Operation select; the numeric values are part of the block's contract.
    typedef enum logic [1:0] {
        BPU_WEAVE   = 2'd0,
        BPU_UNWEAVE = 2'd1,
        BPU_PARITY  = 2'd2,
        BPU_UNPACK  = 2'd3
    } bpu_op_e;

    // Classes of the packed float seen by the unpack path.
    typedef enum logic [1:0] {
        FCLS_SPECIAL,
        FCLS_ZERO,
        FCLS_SUBNORM,
        FCLS_NORMAL
    } fp_class_e;

endpackage

// File: rtl/bpu_bit_weave.sv
// Interleave two half-words into one word, and separate one word into its
// even-indexed and odd-indexed bit streams.
module bpu_bit_weave #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W/2-1:0] odd_src,   // lands on odd result positions
    input  logic [DATA_W/2-1:0] even_src,  // lands on even result positions
    input  logic [DATA_W-1:0]   word_in,
    output logic [DATA_W-1:0]   woven,
    output logic [DATA_W-1:0]   evens,
    output logic [DATA_W-1:0]   odds
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] even_bits;
    logic [HALF-1:0] odd_bits;

    for (genvar k = 0; k < HALF; k++) begin : g_lane
        assign woven[2*k]     = even_src[k];
        assign woven[2*k + 1] = odd_src[k];
        assign even_bits[k]   = word_in[2*k];
        assign odd_bits[k]    = word_in[2*k + 1];
    end

    assign evens = {{HALF{1'b0}}, even_bits};
    assign odds  = {{HALF{1'b0}}, odd_bits};

endmodule

// File: rtl/bpu_byte_parity.sv
// One parity bit per lane, written to the lowest bit of that lane.
module bpu_byte_parity #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] lane_par
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_par[l*LANE_W] = ^word_in[l*LANE_W +: LANE_W];
        if (LANE_W > 1) begin : g_pad
            assign lane_par[l*LANE_W + 1 +: LANE_W - 1] = '0;
        end
    end

endmodule

// File: rtl/bpu_float_unpack.sv
// Splits the magnitude part of a packed float into a signed unbiased exponent
// and a mantissa whose leading one sits just below the top bit of the word.
module bpu_float_unpack
    import bpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W-1:0] fp_mag,
    output logic [DATA_W-1:0]       mant,
    output logic [DATA_W-1:0]       expo
);
    localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_ALL1   = (1 << EXP_W) - 1;
    localparam int MANT_SHIFT = DATA_W - 2 - FRAC_W;

    localparam logic [DATA_W-1:0] BIAS_V    = DATA_W'(BIAS);
    localparam logic [DATA_W-1:0] SPECIAL_V = DATA_W'(EXP_ALL1);
    localparam logic [DATA_W-1:0] ONE_V     = DATA_W'(1);

    logic [EXP_W-1:0]  fld;
    logic [FRAC_W-1:0] frac;
    fp_class_e         cls;
    logic              hidden;

    assign fld  = fp_mag[EXP_W+FRAC_W-1:FRAC_W];
    assign frac = fp_mag[FRAC_W-1:0];

    always_comb begin
        if (fld == EXP_W'(EXP_ALL1)) begin
            cls = FCLS_SPECIAL;
        end else if (fld == '0) begin
            cls = (frac == '0) ? FCLS_ZERO : FCLS_SUBNORM;
        end else begin
            cls = FCLS_NORMAL;
        end
    end

    always_comb begin
        hidden = 1'b0;
        unique case (cls)
            FCLS_SPECIAL: expo = SPECIAL_V;
            FCLS_ZERO:    expo = '0 - BIAS_V;
            FCLS_SUBNORM: expo = ONE_V - BIAS_V;
            default: begin
                expo   = {{(DATA_W-EXP_W){1'b0}}, fld} - BIAS_V;
                hidden = 1'b1;
            end
        endcase
        mant = {1'b0, hidden, frac, {MANT_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
    import bpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi
);
    localparam int HALF  = DATA_W / 2;
    localparam int LANES = DATA_W / LANE_W;
    localparam int MAG_W = EXP_W + FRAC_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } stage_t;

    function automatic logic [DATA_W-1:0] lane_low_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            m[l*LANE_W] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] PAR_MASK = lane_low_bits();

    bpu_op_e           op_e;
    logic [DATA_W-1:0] woven, evens, odds, lane_par, mant, expo;
    stage_t            stage_d, stage_q;

    assign op_e = bpu_op_e'(op);

    bpu_bit_weave #(.DATA_W(DATA_W)) u_weave (
        .odd_src  (opa[HALF-1:0]),
        .even_src (opb[HALF-1:0]),
        .word_in  (opa),
        .woven    (woven),
        .evens    (evens),
        .odds     (odds)
    );

    bpu_byte_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
        .word_in  (opa),
        .lane_par (lane_par)
    );

    // The sign bit is not routed into the unpack path.
    bpu_float_unpack #(.DATA_W(DATA_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .fp_mag (opa[MAG_W-1:0]),
        .mant   (mant),
        .expo   (expo)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            unique case (op_e)
                BPU_WEAVE:   begin stage_d.lo = woven;    stage_d.hi = '0;   end
                BPU_UNWEAVE: begin stage_d.lo = evens;    stage_d.hi = odds; end
                BPU_PARITY:  begin stage_d.lo = lane_par; stage_d.hi = '0;   end
                default:     begin stage_d.lo = mant;     stage_d.hi = expo; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign res_lo    = stage_q.lo;
    assign res_hi    = stage_q.hi;

    // ---------------- assertions ----------------
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && res_lo == '0 && res_hi == '0));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

    assert_weave_hi_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd0) |=> (res_hi == '0));

    assert_unweave_upper_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd1) |=> (res_lo[DATA_W-1:HALF] == '0 && res_hi[DATA_W-1:HALF] == '0));

    assert_parity_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd2) |=> ((res_lo & ~PAR_MASK) == '0 && res_hi == '0));

    assert_normal_hidden_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3 && opa[MAG_W-1:FRAC_W] != '0 && opa[MAG_W-1:FRAC_W] != '1)
        |=> (res_lo[DATA_W-1:DATA_W-2] == 2'b01));

endmodule

// File: tb/bitops_unit_test.sv
`timescale 1ns/1ps
module bitops_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [31:0] opa, opb;
    logic        out_valid;
    logic [31:0] res_lo, res_hi;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bitops_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    // {requirement number, op, opa, opb, expected lo, expected hi}
    localparam int NV = 23;
    localparam logic [133:0] VEC [NV] = '{
        {4'd1, 2'd0, 32'h0000FFFF, 32'h00000000, 32'hAAAAAAAA, 32'h0},  // R1
        {4'd1, 2'd0, 32'h00000000, 32'h0000FFFF, 32'h55555555, 32'h0},  // R1
        {4'd1, 2'd0, 32'h00000001, 32'h00008000, 32'h40000002, 32'h0},  // R1
        {4'd1, 2'd0, 32'hFFFF0000, 32'hFFFF0000, 32'h00000000, 32'h0},  // R1 upper halves
        {4'd2, 2'd1, 32'hAAAAAAAA, 32'h12345678, 32'h00000000, 32'h0000FFFF}, // R2
        {4'd2, 2'd1, 32'h55555555, 32'h00000000, 32'h0000FFFF, 32'h0},  // R2
        {4'd2, 2'd1, 32'h00000006, 32'h00000000, 32'h00000002, 32'h1},  // R2
        {4'd2, 2'd1, 32'h80000001, 32'hFFFFFFFF, 32'h00000001, 32'h00008000}, // R2
        {4'd3, 2'd2, 32'h01030700, 32'h00000000, 32'h01000100, 32'h0},  // R3
        {4'd3, 2'd2, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h0},  // R3
        {4'd3, 2'd2, 32'h80402001, 32'hFFFFFFFF, 32'h01010101, 32'h0},  // R3
        {4'd4, 2'd3, 32'h7F800000, 32'h00000000, 32'h00000000, 32'h000000FF}, // R4
        {4'd4, 2'd3, 32'h7FC00001, 32'h00000000, 32'h20000080, 32'h000000FF}, // R4
        {4'd5, 2'd3, 32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFF81}, // R5
        {4'd6, 2'd3, 32'h00000001, 32'h00000000, 32'h00000080, 32'hFFFFFF82}, // R6
        {4'd6, 2'd3, 32'h007FFFFF, 32'h00000000, 32'h3FFFFF80, 32'hFFFFFF82}, // R6
        {4'd7, 2'd3, 32'h3F800000, 32'h00000000, 32'h40000000, 32'h0},  // R7
        {4'd7, 2'd3, 32'h40490FDB, 32'h00000000, 32'h6487ED80, 32'h1},  // R7
        {4'd7, 2'd3, 32'h00800000, 32'h00000000, 32'h40000000, 32'hFFFFFF82}, // R7
        {4'd7, 2'd3, 32'h7F7FFFFF, 32'h00000000, 32'h7FFFFF80, 32'h0000007F}, // R7
        {4'd8, 2'd3, 32'hBF800000, 32'h00000000, 32'h40000000, 32'h0},  // R8
        {4'd8, 2'd3, 32'h80000000, 32'h00000000, 32'h00000000, 32'hFFFFFF81}, // R8
        {4'd8, 2'd3, 32'hFF800000, 32'h00000000, 32'h00000000, 32'h000000FF}  // R8
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; op = 2'd3; opa = 32'h3F800000; opb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state even with a valid request present
        check("R10", "out_valid after reset", {31'b0, out_valid}, 32'd0);
        check("R10", "res_lo after reset", res_lo, 32'h0);
        check("R10", "res_hi after reset", res_hi, 32'h0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        // Vector table, issued back to back
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag      = $sformatf("R%0d", VEC[i][133:130]);
            op       = VEC[i][129:128];
            opa      = VEC[i][127:96];
            opb      = VEC[i][95:64];
            in_valid = 1'b1;
            @(negedge clk);
            check(tag, "res_lo", res_lo, VEC[i][63:32]);
            check(tag, "res_hi", res_hi, VEC[i][31:0]);
            check("R9", "out_valid streaming", {31'b0, out_valid}, 32'd1);
        end

        // R9 and R11: a single operation followed by idle cycles with other inputs
        op = 2'd0; opa = 32'h0000FFFF; opb = 32'h0; in_valid = 1'b1;
        @(negedge clk);
        check("R9", "out_valid one cycle after issue", {31'b0, out_valid}, 32'd1);
        in_valid = 1'b0; op = 2'd3; opa = 32'h40490FDB; opb = 32'hFFFFFFFF;
        @(negedge clk);
        check("R9", "out_valid after idle", {31'b0, out_valid}, 32'd0);
        check("R11", "res_lo held", res_lo, 32'hAAAAAAAA);
        check("R11", "res_hi held", res_hi, 32'h0);
        op = 2'd1; opa = 32'h55555555;
        @(negedge clk);
        check("R11", "res_lo held second idle", res_lo, 32'hAAAAAAAA);
        check("R11", "res_hi held second idle", res_hi, 32'h0);

        // R10: mid-run reset clears loaded results
        op = 2'd3; opa = 32'h7F800000; in_valid = 1'b1;
        @(negedge clk);
        check("R4", "res_hi before reset", res_hi, 32'h000000FF);
        rst = 1'b1;
        @(negedge clk);
        check("R10", "out_valid mid reset", {31'b0, out_valid}, 32'd0);
        check("R10", "res_hi mid reset", res_hi, 32'h0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule